// File: doc/BRIEF.md
# Transmit Frame FIFO with Replay

This block is the per-port transmit queue between a host that writes 32-bit double words and a MAC transmit engine that takes them one at a time. Every stored entry carries a 33rd bit that marks the final double word of a frame. The host raises that marker together with the last word it writes for a packet.

The queue remembers where the current frame begins. After a collision, the engine can rewind the read side to the first word of that frame and send the frame again. Storage that reads have passed is returned to the writer only once the whole frame has gone out, so the words a rewind points at can never have been overwritten. Each completed frame produces a one-cycle completion pulse and a CRC-append request, the latter held back when the no-CRC mode is selected. If the engine asks for a word in the middle of a frame and none is stored, the frame ends as an underflow: a retry-error output rises and reads stay blocked until a flush. A flush empties the queue and clears every flag.

Top module: `txq_frame_fifo`

## Requirements
- R1: After reset, rd_avail, wr_full, frame_done, crc_req, tx_ok, underflow and retry_err are all 0.
- R2: Words reach the read side in write order. rd_data shows the head word and rd_last shows its end-of-frame bit, both combinationally, from the cycle after the write. A cycle with rd_req high and rd_avail high consumes the head word.
- R3: wr_full is 1 when 2^ADDR_W words are held, counted from the start of the frame that has not yet completed. A write while wr_full is 1 is discarded.
- R4: Reading words of a frame does not lower wr_full. The space those words used is released in the cycle after the frame's last word (the one with rd_last 1) is consumed.
- R5: With rewind high (and flush low), the next word presented on rd_data is the first word of the current, not yet completed frame. Every word of that frame can then be read again. A rewind in the same cycle as rd_req consumes nothing.
- R6: In the cycle after a word with rd_last 1 is consumed, frame_done is 1 for exactly one cycle and tx_ok becomes 1 and stays 1.
- R7: crc_req is 1 together with frame_done when no_crc is 0, and stays 0 when no_crc is 1.
- R8: If rd_req is high while nothing is readable and at least one word of the current frame has been consumed, then from the next cycle retry_err and underflow are 1. They stay 1, and rd_avail stays 0 even if new words are written, until a flush.
- R9: rd_req while nothing is stored and no frame is in progress has no effect: retry_err and underflow stay 0, and a frame written afterwards reads normally.
- R10: A flush empties the queue and clears tx_ok, underflow, retry_err, frame_done and crc_req from the next cycle.
- R11: A flush overrides a write, a rewind and a read in the same cycle. The write is dropped and the queue is empty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one double word |
| wr_data | input | 32 | Double word to store |
| wr_last | input | 1 | Marks the written word as the last of its frame |
| wr_full | output | 1 | No room for another word |
| rd_req | input | 1 | Engine asks for the next word |
| rd_avail | output | 1 | A word is readable |
| rd_data | output | 32 | Head double word |
| rd_last | output | 1 | End-of-frame bit of the head word |
| rewind | input | 1 | Return the read side to the start of the current frame |
| flush | input | 1 | Empty the queue and clear all flags |
| no_crc | input | 1 | Suppress the CRC-append request |
| frame_done | output | 1 | One-cycle pulse after a frame's last word is consumed |
| crc_req | output | 1 | One-cycle request to append the CRC |
| tx_ok | output | 1 | Sticky: a frame completed |
| underflow | output | 1 | Sticky: a frame ran dry |
| retry_err | output | 1 | Sticky retry-error, cleared only by flush |

## Verification
The bench builds the block with ADDR_W=2, so the queue holds four words. A four-word frame fills it completely. Repeated frames move the pointers through several wraps of the one-bit-wider counters. With four words it is practical to sweep every frame length with both CRC modes, and every rewind point inside a full frame. Near these boundaries the held-back space and the full flag interact, and the bench checks wr_full before and after each frame completes.

// File: rtl/txq_frame_fifo_pkg.sv
// Shared types for the transmit frame FIFO.
// Assumes a fixed 32-bit host double word.
package txq_frame_fifo_pkg;
    localparam int TXQ_DATA_W = 32;

    // One stored entry: data plus end-of-frame marker
    typedef struct packed {
        logic                  eof;
        logic [TXQ_DATA_W-1:0] data;
    } txq_entry_t;
endpackage

// File: rtl/txq_store.sv
// Entry storage: 2^ADDR_W entries of type txq_entry_t.
// One write port. The read port is combinational (show-ahead).
// Assumes the caller never writes a slot that is still held.
module txq_store
    import txq_frame_fifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  txq_entry_t        wentry,
    input  logic [ADDR_W-1:0] raddr,
    output txq_entry_t        rentry
);
    localparam int DEPTH = 1 << ADDR_W;

    txq_entry_t slots [DEPTH];

    // Store an accepted entry
    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wentry;
    end

    // Present the head entry
    always_comb rentry = slots[raddr];
endmodule

// File: rtl/txq_ptrs.sv
// Pointer unit: write, read and frame-start pointers, each ADDR_W+1 bits wide.
// Full is measured against the frame-start pointer, so space is released
// only on commit. Empty is measured against the read pointer.
// Assumes push is never asserted while full.
module txq_ptrs #(
    parameter int ADDR_W = 4,
    localparam int PW = ADDR_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic          rewind,
    input  logic          commit,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] sop_ptr,
    output logic          full,
    output logic          empty
);
    // Write pointer advance
    always_ff @(posedge clk) begin
        if (!rst_n || flush) wr_ptr <= '0;
        else if (push)       wr_ptr <= wr_ptr + 1'b1;
    end

    // Read pointer: rewind reloads the frame start, pop advances
    always_ff @(posedge clk) begin
        if (!rst_n || flush) rd_ptr <= '0;
        else if (rewind)     rd_ptr <= sop_ptr;
        else if (pop)        rd_ptr <= rd_ptr + 1'b1;
    end

    // Frame-start pointer: moves past a frame only when it completes
    always_ff @(posedge clk) begin
        if (!rst_n || flush) sop_ptr <= '0;
        else if (commit)     sop_ptr <= rd_ptr + 1'b1;
    end

    // Flags from the extra pointer bit
    always_comb begin
        full  = (wr_ptr[ADDR_W] != sop_ptr[ADDR_W]) &&
                (wr_ptr[ADDR_W-1:0] == sop_ptr[ADDR_W-1:0]);
        empty = (rd_ptr == wr_ptr);
    end
endmodule

// File: rtl/txq_frame_ctrl.sv
// Frame control: decides pops, commits and underflow, and holds the
// completion pulses and sticky flags.
// Priority: flush, then rewind, then read.
module txq_frame_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic rewind,
    input  logic flush,
    input  logic no_crc,
    input  logic empty,
    input  logic head_eof,
    output logic rd_avail,
    output logic pop,
    output logic commit,
    output logic frame_done,
    output logic crc_req,
    output logic tx_ok,
    output logic underflow,
    output logic retry_err
);
    logic in_frame;
    logic uf_evt;

    // Read-side decisions
    always_comb begin
        rd_avail = !empty && !retry_err;
        pop      = rd_req && rd_avail && !flush && !rewind;
        commit   = pop && head_eof;
        uf_evt   = rd_req && empty && in_frame && !retry_err && !flush && !rewind;
    end

    // Track whether part of a frame has been consumed
    always_ff @(posedge clk) begin
        if (!rst_n || flush)    in_frame <= 1'b0;
        else if (rewind)        in_frame <= 1'b0;
        else if (uf_evt)        in_frame <= 1'b0;
        else if (pop)           in_frame <= !head_eof;
    end

    // Completion pulses, one cycle after the last word is consumed
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            frame_done <= 1'b0;
            crc_req    <= 1'b0;
        end else begin
            frame_done <= commit;
            crc_req    <= commit && !no_crc;
        end
    end

    // Sticky flags, cleared only by reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            tx_ok     <= 1'b0;
            underflow <= 1'b0;
            retry_err <= 1'b0;
        end else begin
            if (commit) tx_ok     <= 1'b1;
            if (uf_evt) underflow <= 1'b1;
            if (uf_evt) retry_err <= 1'b1;
        end
    end
endmodule

// File: rtl/txq_frame_fifo.sv
// Transmit frame FIFO top: joins the storage, pointers and frame control.
// Assumes a single clock and that the host raises wr_last with the
// final word of each frame.
module txq_frame_fifo
    import txq_frame_fifo_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int PW = ADDR_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TXQ_DATA_W-1:0] wr_data,
    input  logic                  wr_last,
    output logic                  wr_full,
    input  logic                  rd_req,
    output logic                  rd_avail,
    output logic [TXQ_DATA_W-1:0] rd_data,
    output logic                  rd_last,
    input  logic                  rewind,
    input  logic                  flush,
    input  logic                  no_crc,
    output logic                  frame_done,
    output logic                  crc_req,
    output logic                  tx_ok,
    output logic                  underflow,
    output logic                  retry_err
);
    logic [PW-1:0] wr_ptr, rd_ptr, sop_ptr;
    logic          full, empty, push, pop, commit;
    txq_entry_t    wentry, rentry;

    // Write acceptance and entry packing
    always_comb begin
        push        = wr_en && !full && !flush;
        wentry.data = wr_data;
        wentry.eof  = wr_last;
        wr_full     = full;
        rd_data     = rentry.data;
        rd_last     = rentry.eof;
    end

    txq_store #(.ADDR_W(ADDR_W)) u_store (
        .clk    (clk),
        .we     (push),
        .waddr  (wr_ptr[ADDR_W-1:0]),
        .wentry (wentry),
        .raddr  (rd_ptr[ADDR_W-1:0]),
        .rentry (rentry)
    );

    txq_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .push    (push),
        .pop     (pop),
        .rewind  (rewind),
        .commit  (commit),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .sop_ptr (sop_ptr),
        .full    (full),
        .empty   (empty)
    );

    txq_frame_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .rewind     (rewind),
        .flush      (flush),
        .no_crc     (no_crc),
        .empty      (empty),
        .head_eof   (rentry.eof),
        .rd_avail   (rd_avail),
        .pop        (pop),
        .commit     (commit),
        .frame_done (frame_done),
        .crc_req    (crc_req),
        .tx_ok      (tx_ok),
        .underflow  (underflow),
        .retry_err  (retry_err)
    );
endmodule

// File: rtl/txq_frame_fifo_chk.sv
// Checker for txq_frame_fifo, attached by bind. Reads ports and pointers.
module txq_frame_fifo_chk #(
    parameter int ADDR_W = 4,
    localparam int PW = ADDR_W + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic          rd_avail,
    input logic          rd_last,
    input logic          rewind,
    input logic          flush,
    input logic          frame_done,
    input logic          crc_req,
    input logic          retry_err,
    input logic          wr_full,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rd_ptr,
    input logic [PW-1:0] sop_ptr
);
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr - sop_ptr) <= DEPTH_P);

    // R4
    rd_inside_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr - sop_ptr) <= (wr_ptr - sop_ptr));

    // R5
    rewind_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind && !flush) |=> (rd_ptr == $past(sop_ptr)));

    // R6
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(rd_req && rd_avail && rd_last && !rewind && !flush));

    // R7
    crc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_req |-> frame_done);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry_err) |-> $past(rd_req && !rd_avail));

    // R8
    err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_err |-> !rd_avail);

    // R10
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!retry_err && !rd_avail && !wr_full && !frame_done));
endmodule

bind txq_frame_fifo txq_frame_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_avail   (rd_avail),
    .rd_last    (rd_last),
    .rewind     (rewind),
    .flush      (flush),
    .frame_done (frame_done),
    .crc_req    (crc_req),
    .retry_err  (retry_err),
    .wr_full    (wr_full),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .sop_ptr    (sop_ptr)
);

// File: tb/txq_frame_fifo_bench.sv
module txq_frame_fifo_bench;
    localparam int AW    = 2;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_last = 1'b0, rd_req = 1'b0;
    logic        rewind = 1'b0, flush = 1'b0, no_crc = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_full, rd_avail, rd_last, frame_done, crc_req;
    logic        tx_ok, underflow, retry_err;
    logic [31:0] rd_data;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    txq_frame_fifo #(.ADDR_W(AW)) u_txq_frame_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_last(wr_last), .wr_full(wr_full), .rd_req(rd_req),
        .rd_avail(rd_avail), .rd_data(rd_data), .rd_last(rd_last),
        .rewind(rewind), .flush(flush), .no_crc(no_crc),
        .frame_done(frame_done), .crc_req(crc_req), .tx_ok(tx_ok),
        .underflow(underflow), .retry_err(retry_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] d, input logic last);
        wr_en = 1'b1; wr_data = d; wr_last = last;
        step();
        wr_en = 1'b0; wr_last = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [31:0] d, input logic last);
        chk(req, {31'd0, rd_avail}, 32'd1);
        chk(req, rd_data, d);
        chk(req, {31'd0, rd_last}, {31'd0, last});
        rd_req = 1'b1;
        step();
        rd_req = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        step();
        flush = 1'b0;
    endtask

    function automatic logic [31:0] word(input int tag, input int i);
        return 32'hC000_0000 + 32'(tag) * 32'h100 + 32'(i);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1", {25'd0, rd_avail, wr_full, frame_done, crc_req, tx_ok, underflow, retry_err}, 32'd0);

        // R2 R3 R4 R6 R7: every length, both CRC modes
        for (int nc = 0; nc < 2; nc++) begin
            for (int len = 1; len <= DEPTH; len++) begin
                no_crc = nc[0];
                for (int i = 0; i < len; i++) push(word(len + 8 * nc, i), i == len - 1);
                chk("R3", {31'd0, wr_full}, {31'd0, len == DEPTH});
                for (int i = 0; i < len; i++) begin
                    pop_chk("R2", word(len + 8 * nc, i), i == len - 1);
                    if (i < len - 1) begin
                        chk("R6", {31'd0, frame_done}, 32'd0);
                        chk("R4", {31'd0, wr_full}, {31'd0, len == DEPTH});
                    end
                end
                chk("R6", {31'd0, frame_done}, 32'd1);
                chk("R6", {31'd0, tx_ok}, 32'd1);
                chk("R7", {31'd0, crc_req}, {31'd0, nc == 0});
                chk("R4", {31'd0, wr_full}, 32'd0);
                chk("R2", {31'd0, rd_avail}, 32'd0);
                step();
                chk("R6", {31'd0, frame_done}, 32'd0);
            end
        end
        no_crc = 1'b0;

        // R3: write while full is dropped
        for (int i = 0; i < DEPTH; i++) push(word(40, i), i == DEPTH - 1);
        push(32'hDEAD_BEEF, 1'b1);
        chk("R3", {31'd0, wr_full}, 32'd1);
        for (int i = 0; i < DEPTH; i++) pop_chk("R3", word(40, i), i == DEPTH - 1);
        chk("R3", {31'd0, rd_avail}, 32'd0);
        step();

        // R5: rewind from each point inside a full frame
        for (int k = 1; k < DEPTH; k++) begin
            for (int i = 0; i < DEPTH; i++) push(word(50 + k, i), i == DEPTH - 1);
            for (int i = 0; i < k; i++) pop_chk("R5", word(50 + k, i), 1'b0);
            rewind = 1'b1; rd_req = 1'b1;
            step();
            rewind = 1'b0; rd_req = 1'b0;
            chk("R5", rd_data, word(50 + k, 0));
            chk("R4", {31'd0, wr_full}, 32'd1);
            for (int i = 0; i < DEPTH; i++) pop_chk("R5", word(50 + k, i), i == DEPTH - 1);
            chk("R5", {31'd0, frame_done}, 32'd1);
            step();
        end

        // R9: request while idle and empty
        rd_req = 1'b1; step(); rd_req = 1'b0; step();
        chk("R9", {30'd0, underflow, retry_err}, 32'd0);
        push(word(60, 0), 1'b1);
        pop_chk("R9", word(60, 0), 1'b1);
        chk("R9", {31'd0, frame_done}, 32'd1);

        // R8: underflow mid-frame
        push(word(70, 0), 1'b0);
        push(word(70, 1), 1'b0);
        pop_chk("R8", word(70, 0), 1'b0);
        pop_chk("R8", word(70, 1), 1'b0);
        rd_req = 1'b1; step(); rd_req = 1'b0;
        chk("R8", {30'd0, underflow, retry_err}, 32'd3);
        push(word(70, 2), 1'b1);
        step();
        chk("R8", {31'd0, rd_avail}, 32'd0);
        chk("R8", {30'd0, underflow, retry_err}, 32'd3);

        // R10: flush clears everything
        do_flush();
        chk("R10", {27'd0, rd_avail, wr_full, tx_ok, underflow, retry_err}, 32'd0);
        push(word(80, 0), 1'b1);
        pop_chk("R10", word(80, 0), 1'b1);

        // R11: flush beats write, rewind and read in the same cycle
        push(word(90, 0), 1'b0);
        push(word(90, 1), 1'b0);
        flush = 1'b1; wr_en = 1'b1; wr_data = word(90, 2); rewind = 1'b1; rd_req = 1'b1;
        step();
        flush = 1'b0; wr_en = 1'b0; rewind = 1'b0; rd_req = 1'b0;
        chk("R11", {30'd0, rd_avail, wr_full}, 32'd0);
        step();
        chk("R11", {31'd0, rd_avail}, 32'd0);
        push(word(91, 0), 1'b1);
        pop_chk("R11", word(91, 0), 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule